// File: doc/BRIEF.md
# Fan PWM Generator with Programmable Edge Points

This block drives one fan PWM pin. A two-stage prescaler divides the system clock. The first stage divides by a power of two and the second by a small linear factor. The prescaler's tick advances an 8-bit period counter that runs from zero up to a programmed period value and then wraps. The output is set when the counter reaches a programmed rising point and cleared when it reaches a programmed falling point. Duty is therefore the span between those two points, and it may wrap around the end of the period.

The period, rising point and falling point are held in shadow registers. While the port is enabled, the shadows load only when the counter wraps, so a change never cuts a period short. While the port is disabled, the shadows follow the inputs, so a port that has just been enabled starts with the current settings. Two corner cases are handled. Equal rising and falling points give a constant high output. Clearing the port enable gives a constant low output.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset the output is low and the period counter, the prescaler and the shadow registers are zero.
- R2: The division factor D is the product of two factors. The first is 2 to the power of the high divider code. The second is 1 when the low divider code is 0 and otherwise twice that code. One output period lasts D*(P+1) clock cycles, where P is the period value.
- R3: While enabled, the counter advances on each prescaler tick, goes from 0 up to P, and wraps to 0 on the tick after P. It never exceeds the captured period.
- R4: When rising point ≠ falling point, the output goes high one cycle after the counter holds the rising point and low one cycle after it holds the falling point. The high time is ((fall − rise) mod (P+1))*D cycles, so a rising point above the falling point wraps the pulse across the period end.
- R5: When the captured rising and falling points are equal, the output is high in every cycle (full on).
- R6: With the port enable low, the output is low from the next cycle on, whatever the other inputs are. The counter and prescaler are cleared and the shadows follow the inputs.
- R7: With the clock enable low, the prescaler, the counter and the output hold their values.
- R8: While enabled, new period, rising and falling values take effect only at the counter wrap. The period in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Global prescaler enable |
| port_en | input | 1 | Port enable; low forces the output low |
| div_hi_code | input | HI_W (3) | Power-of-two divider code |
| div_lo_code | input | LO_W (4) | Linear divider code |
| period | input | CNT_W (8) | Last counter value of a period |
| rise_pt | input | CNT_W (8) | Counter value that sets the output |
| fall_pt | input | CNT_W (8) | Counter value that clears the output |
| pwm_out | output | 1 | PWM output pin |

## Verification
The output register lags the counter by one cycle, so an edge appears one clock after the counter reaches a compare point. A change of the port enable is visible on the output at the next clock. The bench drives inputs on falling edges and counts output cycles on falling edges. It syncs on an output rising edge and then measures high and low spans, which are expected to equal multiples of D. Freeze checks take their reference value one cycle after clock enable drops, because the output register may still complete one pending update. The shadow test changes the period right after an observed rising edge. It expects one more period of the old length, and then periods of the new length.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    localparam int HI_W_DEF  = 3;
    localparam int LO_W_DEF  = 4;
    localparam int CNT_W_DEF = 8;
endpackage

// File: rtl/fpg_prescaler.sv
module fpg_prescaler #(
    parameter int HI_W = fpg_pkg::HI_W_DEF,
    parameter int LO_W = fpg_pkg::LO_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    input  logic [HI_W-1:0] hi_code,
    input  logic [LO_W-1:0] lo_code,
    output logic            tick
);
    localparam int A_W = (1 << HI_W) - 1;
    localparam int B_W = LO_W + 1;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
    } pre_t;

    pre_t           st_d, st_q;
    logic [A_W-1:0] a_lim;
    logic [B_W-1:0] b_lim;
    logic           a_term, b_term;

    always_comb begin
        a_lim  = ~({A_W{1'b1}} << hi_code);
        b_lim  = (lo_code == '0) ? '0 : ({lo_code, 1'b0} - B_W'(1));
        a_term = (st_q.a >= a_lim);
        b_term = (st_q.b >= b_lim);
        tick   = run && !clr && a_term && b_term;
        st_d   = st_q;
        if (clr) begin
            st_d = '0;
        end else if (run) begin
            if (a_term) begin
                st_d.a = '0;
                st_d.b = b_term ? '0 : st_q.b + B_W'(1);
            end else begin
                st_d.a = st_q.a + A_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fpg_period.sv
module fpg_period #(
    parameter int CNT_W = fpg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] rise_in,
    input  logic [CNT_W-1:0] fall_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] rise_sh,
    output logic [CNT_W-1:0] fall_sh
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] rise;
        logic [CNT_W-1:0] fall;
    } per_t;

    per_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en || (tick && st_q.cnt >= st_q.per)) begin
            st_d.cnt  = '0;
            st_d.per  = per_in;
            st_d.rise = rise_in;
            st_d.fall = fall_in;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign per_sh  = st_q.per;
    assign rise_sh = st_q.rise;
    assign fall_sh = st_q.fall;
endmodule

// File: rtl/fpg_edge.sv
module fpg_edge #(
    parameter int CNT_W = fpg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] rise,
    input  logic [CNT_W-1:0] fall,
    output logic             pwm
);
    logic out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (!en)                out_d = 1'b0;
        else if (rise == fall)  out_d = 1'b1;
        else if (cnt == rise)   out_d = 1'b1;
        else if (cnt == fall)   out_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign pwm = out_q;
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
    parameter int HI_W  = fpg_pkg::HI_W_DEF,
    parameter int LO_W  = fpg_pkg::LO_W_DEF,
    parameter int CNT_W = fpg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             port_en,
    input  logic [HI_W-1:0]  div_hi_code,
    input  logic [LO_W-1:0]  div_lo_code,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] rise_pt,
    input  logic [CNT_W-1:0] fall_pt,
    output logic             pwm_out
);
    logic             tick;
    logic [CNT_W-1:0] cnt_w, per_w, rise_w, fall_w;

    fpg_prescaler #(.HI_W(HI_W), .LO_W(LO_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(!port_en), .run(clk_en),
        .hi_code(div_hi_code), .lo_code(div_lo_code), .tick(tick)
    );

    fpg_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .en(port_en), .tick(tick),
        .per_in(period), .rise_in(rise_pt), .fall_in(fall_pt),
        .cnt(cnt_w), .per_sh(per_w), .rise_sh(rise_w), .fall_sh(fall_w)
    );

    fpg_edge #(.CNT_W(CNT_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .en(port_en), .cnt(cnt_w),
        .rise(rise_w), .fall(fall_w), .pwm(pwm_out)
    );
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
    parameter int CNT_W = fpg_pkg::CNT_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             port_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_sh,
    input logic [CNT_W-1:0] rise_sh,
    input logic [CNT_W-1:0] fall_sh,
    input logic             pwm_out
);
    a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_sh);

    a_r4_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && cnt == rise_sh && rise_sh != fall_sh) |=> pwm_out);

    a_r4_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && cnt == fall_sh && rise_sh != fall_sh) |=> !pwm_out);

    a_r5_full_on: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && rise_sh == fall_sh) |=> pwm_out);

    a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !pwm_out);

    a_r7_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !clk_en) |=> $stable(cnt));

    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> (cnt == '0 || ($stable(per_sh) && $stable(rise_sh) && $stable(fall_sh))));
endmodule

bind fan_pwm_gen fpg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
    .cnt(cnt_w), .per_sh(per_w), .rise_sh(rise_w), .fall_sh(fall_w),
    .pwm_out(pwm_out)
);

// File: tb/fan_pwm_gen_bench.sv
`timescale 1ns/1ps
module fan_pwm_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       port_en = 1'b0;
    logic [2:0] div_hi_code = '0;
    logic [3:0] div_lo_code = '0;
    logic [7:0] period = '0;
    logic [7:0] rise_pt = '0;
    logic [7:0] fall_pt = '0;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    fan_pwm_gen u_fan_pwm_gen (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
        .div_hi_code(div_hi_code), .div_lo_code(div_lo_code),
        .period(period), .rise_pt(rise_pt), .fall_pt(fall_pt),
        .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int dfac(input int hi, input int lo);
        return (1 << hi) * ((lo == 0) ? 1 : 2 * lo);
    endfunction

    task automatic wait_level(input logic lvl, output int ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pwm_out == lvl) begin ok = 1; break; end
        end
    endtask

    // Counts high then low cycles starting at the current sample (output high).
    task automatic span_from_high(output int h, output int p);
        int l;
        h = 0; l = 0;
        while (pwm_out == 1'b1 && h < 20000) begin h++; @(negedge clk); end
        while (pwm_out == 1'b0 && l < 20000) begin l++; @(negedge clk); end
        p = h + l;
    endtask

    task automatic measure(output int h, output int p);
        int ok;
        h = -1; p = -1;
        wait_level(1'b0, ok);
        if (ok == 0) return;
        wait_level(1'b1, ok);
        if (ok == 0) return;
        span_from_high(h, p);
    endtask

    task automatic setup(input int hi, input int lo, input int per,
                         input int r, input int f);
        @(negedge clk);
        port_en     = 1'b0;
        div_hi_code = 3'(hi);
        div_lo_code = 4'(lo);
        period      = 8'(per);
        rise_pt     = 8'(r);
        fall_pt     = 8'(f);
        repeat (3) @(negedge clk);
        port_en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 output low in reset", int'(pwm_out), 0);
        @(negedge clk); rst_n = 1'b1; clk_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 output low after reset, port off", int'(pwm_out), 0);
    endtask

    task automatic t_div(input string req, input int hi, input int lo,
                         input int per, input int r, input int f);
        int h, p, d, hexp;
        d    = dfac(hi, lo);
        hexp = ((f - r + per + 1) % (per + 1)) * d;
        setup(hi, lo, per, r, f);
        measure(h, p);
        chk({req, " period cycles"}, p, d * (per + 1));
        chk({req, " high cycles"}, h, hexp);
    endtask

    task automatic t_full_on();
        int highs = 0;
        setup(1, 2, 9, 5, 5);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            highs += int'(pwm_out);
        end
        chk("R5 equal points keep output high", highs, 200);
    endtask

    task automatic t_disable();
        int highs = 0;
        setup(0, 0, 9, 3, 3);
        repeat (5) @(negedge clk);
        chk("R5 full on before disable", int'(pwm_out), 1);
        port_en = 1'b0;
        @(negedge clk);
        chk("R6 low one cycle after disable", int'(pwm_out), 0);
        rise_pt = 8'd0; fall_pt = 8'd4;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            highs += int'(pwm_out);
        end
        chk("R6 output stays low while disabled", highs, 0);
    endtask

    task automatic t_freeze();
        int h, p, chg = 0;
        logic ref_v;
        setup(0, 0, 9, 2, 7);
        repeat (13) @(negedge clk);
        clk_en = 1'b0;
        @(negedge clk);
        ref_v = pwm_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_out != ref_v) chg++;
        end
        chk("R7 output held while clock enable low", chg, 0);
        clk_en = 1'b1;
        measure(h, p);
        chk("R7 period after resume", p, 10);
        chk("R7 high after resume", h, 5);
    endtask

    task automatic t_shadow();
        int h, p, ok;
        setup(0, 0, 9, 0, 1);
        wait_level(1'b0, ok);
        wait_level(1'b1, ok);
        period = 8'd4;
        span_from_high(h, p);
        chk("R8 period in progress keeps old length", p, 10);
        span_from_high(h, p);
        chk("R8 new period after wrap", p, 5);
        chk("R8 high after wrap", h, 1);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_div("R2 R3 R4 no division", 0, 0, 9, 2, 7);
        t_div("R2 low code 1 high code 1", 1, 1, 4, 0, 1);
        t_div("R2 high code 2 low code 3", 2, 3, 4, 1, 3);
        t_div("R4 rise after fall wraps", 0, 0, 9, 7, 2);
        t_div("R2 high code 3 only", 3, 0, 3, 1, 2);
        t_full_on();
        t_disable();
        t_freeze();
        t_shadow();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule